// File: doc/BRIEF.md
# Microcontroller Bus Register Bridge

This block sits beside a small microcontroller that uses a multiplexed address/data bus. It gives the application logic a window of four byte-wide registers. The microcontroller first places the low address byte on the shared bus and qualifies it with an address-latch strobe. The bridge captures that byte, together with a separate upper address byte, on the falling edge of the strobe. The read and write strobes that follow are asynchronous to the bridge's own clock. They are brought into that clock domain through a parameterised flip-flop chain.

The four registers are a status byte made from the application's flags, a control byte that drives the application's enable, start and five general control lines, an input-data byte written by the processor and passed to the application, and an output-data byte loaded by the application and read by the processor. Some accesses also send a one-cycle clear pulse back to the application, so that it can drop a sticky flag. An active-low interrupt line tells the processor that a flag needs attention. Program-fetch cycles on the same bus never touch the registers. Read data leaves the block on an output byte with a separate drive enable, which the pad ring uses to build the tri-state bus.

Top module: `mcu_regbridge`

## Requirements
- R1: After reset, the outputs `app_en`, `start`, `ctrl_bits`, `data_to_app`, `ad_oe` and all three clear pulses are 0, and `int_n` is 1.
- R2: The register is selected by the address present on `ad_i` when `ale` falls. A data byte on the bus that looks like another register's address does not redirect the access.
- R3: A register is selected only when the latched upper address equals the base (00h). With any other base, a write changes nothing and a read never asserts `ad_oe`.
- R4: The control register sits at low address 82h. Bit 7 is `app_en`, bit 6 is `start` and bits 4:0 are `ctrl_bits`. Bit 5 is not stored and reads as 0.
- R5: A write to 84h sets `data_to_app`, and reading 84h returns that value. Each such write produces exactly one single-cycle `clr_need` pulse.
- R6: A one-cycle `app_load` captures `app_word` into the output register, which is read at 86h. Processor writes to 86h are ignored. Each read of 86h produces exactly one single-cycle `clr_ready` pulse.
- R7: The status register at 80h reads as done in bit 7, error in bit 6, need in bit 4 and ready in bit 3. All other bits read as 0.
- R8: A status read produces one single-cycle `clr_error` pulse if `flag_error` is high when the read strobe ends, and no pulse otherwise.
- R9: `ad_oe` is high only while `rd_n` is low, `psen_n` is high and the latched address hits one of the four registers.
- R10: An access made while `psen_n` is low neither writes a register, nor drives the bus, nor produces a clear pulse.
- R11: `int_n` goes low one clock after `app_en` is high with any flag set, and is high otherwise.
- R12: A write stores the byte present while `wr_n` was low, even if the bus changes at the instant `wr_n` rises.
- R13: Low addresses other than 80h, 82h, 84h and 86h are unmapped. Writes to them change no register, and reads from them do not drive the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ale | input | 1 | Address-latch strobe; the address is captured on its falling edge |
| addr_hi | input | 8 | Upper address byte |
| ad_i | input | 8 | Shared address/data bus as received from the pad |
| ad_o | output | 8 | Read data toward the pad |
| ad_oe | output | 1 | Pad drive enable for `ad_o` |
| rd_n | input | 1 | Read strobe, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| psen_n | input | 1 | Program-fetch strobe, active low |
| flag_done | input | 1 | Application done flag |
| flag_error | input | 1 | Application error flag |
| flag_need | input | 1 | Application needs-data flag |
| flag_ready | input | 1 | Application data-ready flag |
| app_load | input | 1 | Loads `app_word` into the output register |
| app_word | input | 8 | Data from the application |
| data_to_app | output | 8 | Input-data register contents |
| app_en | output | 1 | Application enable (control bit 7) |
| start | output | 1 | Start control (control bit 6) |
| ctrl_bits | output | 5 | General control lines (control bits 4:0) |
| clr_error | output | 1 | One-cycle clear for the error flag |
| clr_need | output | 1 | One-cycle clear for the needs-data flag |
| clr_ready | output | 1 | One-cycle clear for the data-ready flag |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The hardest case to reach is the write strobe's trailing edge when the bus changes at that same instant. A correct bridge must commit the byte it saw while the strobe was low, not whatever follows. The bench drives the inverse of the write byte onto `ad_i` at the exact moment it raises `wr_n`, so any design that samples late stores the wrong value. A second hard case is a data phase that resembles a register address: the control write carries 84h as data. Program-fetch, foreign-base and unmapped accesses are replayed with the same bus timing, so that only the qualifier differs.

// File: rtl/mrb_pkg.sv
package mrb_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_CTRL,
      SEL_DIN,
      SEL_DOUT
   } reg_sel_e;

   // register offsets from the bank base
   localparam int OFS_STAT = 0;
   localparam int OFS_CTRL = 2;
   localparam int OFS_DIN  = 4;
   localparam int OFS_DOUT = 6;

   // status bit positions
   localparam int ST_DONE  = 7;
   localparam int ST_ERROR = 6;
   localparam int ST_NEED  = 4;
   localparam int ST_READY = 3;

   // control bit positions
   localparam int CT_EN    = 7;
   localparam int CT_START = 6;
   localparam int CT_LOW_W = 5;

endpackage

// File: rtl/mrb_addr_latch.sv
module mrb_addr_latch #(
   parameter int ADDR_W = 8
) (
   input  logic                  rst_n,
   input  logic                  ale,
   input  logic [ADDR_W-1:0]     hi_i,
   input  logic [ADDR_W-1:0]     lo_i,
   output logic [2*ADDR_W-1:0]   addr_q
);

   // capture on the strobe's falling edge, while the address is still held
   always_ff @(negedge ale or negedge rst_n) begin
      if (!rst_n) addr_q <= '0;
      else        addr_q <= {hi_i, lo_i};
   end

endmodule

// File: rtl/mrb_strobe_sync.sv
module mrb_strobe_sync #(
   parameter int ADDR_W = 8,
   parameter int DATA_W = 8,
   parameter int STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  rd_n,
   input  logic                  wr_n,
   input  logic                  psen_n,
   input  logic [DATA_W-1:0]     ad_i,
   input  logic [2*ADDR_W-1:0]   addr_i,
   output logic                  wr_commit,
   output logic                  rd_finish,
   output logic [2*ADDR_W-1:0]   cyc_addr,
   output logic [DATA_W-1:0]     cyc_data
);

   localparam int AW2  = 2*ADDR_W;
   localparam int P_WR = DATA_W + AW2;
   localparam int P_RD = P_WR + 1;
   localparam int P_PS = P_WR + 2;
   localparam int BW   = P_PS + 1;
   localparam logic [BW-1:0] IDLE = {3'b111, {(BW-3){1'b0}}};

   logic [STAGES-1:0][BW-1:0] stg;
   logic [BW-1:0]             cur;
   logic [2:0]                prv_q;   // {psen_n, rd_n, wr_n} one stage behind cur

   assign cur = stg[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stg   <= {STAGES{IDLE}};
         prv_q <= 3'b111;
      end else begin
         stg[0] <= {psen_n, rd_n, wr_n, addr_i, ad_i};
         for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
         prv_q <= cur[P_PS:P_WR];
      end
   end

   // hold address and data from the last cycle a strobe was seen low
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_addr <= '0;
         cyc_data <= '0;
      end else if (!cur[P_WR] || !cur[P_RD]) begin
         cyc_addr <= cur[P_WR-1:DATA_W];
         cyc_data <= cur[DATA_W-1:0];
      end
   end

   // trailing-edge detection, qualified by the fetch strobe of the last low sample
   assign wr_commit = cur[P_WR] && !prv_q[0] && prv_q[2];
   assign rd_finish = cur[P_RD] && !prv_q[1] && prv_q[2];

endmodule

// File: rtl/mrb_regfile.sv
module mrb_regfile
   import mrb_pkg::*;
#(
   parameter int                ADDR_W         = 8,
   parameter int                DATA_W         = 8,
   parameter logic [ADDR_W-1:0] BASE_HI        = '0,
   parameter logic [ADDR_W-1:0] BANK_LO        = 8'h80,
   parameter bit                INT_REGISTERED = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_commit,
   input  logic                  rd_finish,
   input  logic [2*ADDR_W-1:0]   cyc_addr,
   input  logic [DATA_W-1:0]     cyc_data,
   input  logic [2*ADDR_W-1:0]   live_addr,
   input  logic                  rd_n,
   input  logic                  psen_n,
   input  logic                  flag_done,
   input  logic                  flag_error,
   input  logic                  flag_need,
   input  logic                  flag_ready,
   input  logic                  app_load,
   input  logic [DATA_W-1:0]     app_word,
   output logic [DATA_W-1:0]     ad_o,
   output logic                  ad_oe,
   output logic [DATA_W-1:0]     data_to_app,
   output logic                  app_en,
   output logic                  start,
   output logic [CT_LOW_W-1:0]   ctrl_bits,
   output logic                  clr_error,
   output logic                  clr_need,
   output logic                  clr_ready,
   output logic                  int_n
);

   localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(BANK_LO + ADDR_W'(OFS_STAT));
   localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(BANK_LO + ADDR_W'(OFS_CTRL));
   localparam logic [ADDR_W-1:0] A_DIN  = ADDR_W'(BANK_LO + ADDR_W'(OFS_DIN));
   localparam logic [ADDR_W-1:0] A_DOUT = ADDR_W'(BANK_LO + ADDR_W'(OFS_DOUT));
   localparam logic [DATA_W-1:0] CTRL_MASK =
      DATA_W'((1 << CT_EN) | (1 << CT_START) | ((1 << CT_LOW_W) - 1));

   function automatic reg_sel_e decode(input logic [2*ADDR_W-1:0] a);
      reg_sel_e s;
      s = SEL_NONE;
      if (a[2*ADDR_W-1:ADDR_W] == BASE_HI) begin
         if      (a[ADDR_W-1:0] == A_STAT) s = SEL_STAT;
         else if (a[ADDR_W-1:0] == A_CTRL) s = SEL_CTRL;
         else if (a[ADDR_W-1:0] == A_DIN)  s = SEL_DIN;
         else if (a[ADDR_W-1:0] == A_DOUT) s = SEL_DOUT;
      end
      return s;
   endfunction

   reg_sel_e            live_sel, cyc_sel;
   logic [DATA_W-1:0]   ctrl_q, din_q, dout_q, status;
   logic                any_flag;

   assign live_sel = decode(live_addr);
   assign cyc_sel  = decode(cyc_addr);
   assign any_flag = flag_done | flag_error | flag_need | flag_ready;

   always_comb begin
      status           = '0;
      status[ST_DONE]  = flag_done;
      status[ST_ERROR] = flag_error;
      status[ST_NEED]  = flag_need;
      status[ST_READY] = flag_ready;
   end

   // processor-written registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         din_q  <= '0;
      end else if (wr_commit) begin
         if (cyc_sel == SEL_CTRL) ctrl_q <= cyc_data & CTRL_MASK;
         if (cyc_sel == SEL_DIN)  din_q  <= cyc_data;
      end
   end

   // application-written register
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        dout_q <= '0;
      else if (app_load) dout_q <= app_word;
   end

   // flag clear pulses, one clock each
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         clr_error <= 1'b0;
         clr_need  <= 1'b0;
         clr_ready <= 1'b0;
      end else begin
         clr_error <= rd_finish && (cyc_sel == SEL_STAT) && flag_error;
         clr_ready <= rd_finish && (cyc_sel == SEL_DOUT);
         clr_need  <= wr_commit && (cyc_sel == SEL_DIN);
      end
   end

   // read path straight from the raw strobe so the bus is released at once
   always_comb begin
      case (live_sel)
         SEL_STAT: ad_o = status;
         SEL_CTRL: ad_o = ctrl_q;
         SEL_DIN:  ad_o = din_q;
         SEL_DOUT: ad_o = dout_q;
         default:  ad_o = '0;
      endcase
   end
   assign ad_oe = !rd_n && psen_n && (live_sel != SEL_NONE);

   assign data_to_app = din_q;
   assign app_en      = ctrl_q[CT_EN];
   assign start       = ctrl_q[CT_START];
   assign ctrl_bits   = ctrl_q[CT_LOW_W-1:0];

   generate
      if (INT_REGISTERED) begin : g_int_reg
         logic int_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) int_q <= 1'b1;
            else        int_q <= !(app_en && any_flag);
         end
         assign int_n = int_q;
      end else begin : g_int_comb
         assign int_n = !(app_en && any_flag);
      end
   endgenerate

endmodule

// File: rtl/mcu_regbridge.sv
module mcu_regbridge
   import mrb_pkg::*;
#(
   parameter int                ADDR_W         = 8,
   parameter int                DATA_W         = 8,
   parameter logic [ADDR_W-1:0] BASE_HI        = '0,
   parameter logic [ADDR_W-1:0] BANK_LO        = 8'h80,
   parameter int                SYNC_STAGES    = 2,
   parameter bit                INT_REGISTERED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                ale,
   input  logic [ADDR_W-1:0]   addr_hi,
   input  logic [DATA_W-1:0]   ad_i,
   output logic [DATA_W-1:0]   ad_o,
   output logic                ad_oe,
   input  logic                rd_n,
   input  logic                wr_n,
   input  logic                psen_n,
   input  logic                flag_done,
   input  logic                flag_error,
   input  logic                flag_need,
   input  logic                flag_ready,
   input  logic                app_load,
   input  logic [DATA_W-1:0]   app_word,
   output logic [DATA_W-1:0]   data_to_app,
   output logic                app_en,
   output logic                start,
   output logic [CT_LOW_W-1:0] ctrl_bits,
   output logic                clr_error,
   output logic                clr_need,
   output logic                clr_ready,
   output logic                int_n
);

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (DATA_W < 8) begin : g_bad_data
         $error("DATA_W must hold the 8 control and status bits");
      end
      if (ADDR_W > DATA_W) begin : g_bad_addr
         $error("low address must fit on the shared bus");
      end
      if (ADDR_W < 3) begin : g_bad_map
         $error("ADDR_W too small for the register map");
      end
   endgenerate

   logic [2*ADDR_W-1:0] live_addr, cyc_addr;
   logic [DATA_W-1:0]   cyc_data;
   logic                wr_commit, rd_finish;

   mrb_addr_latch #(.ADDR_W(ADDR_W)) u_latch (
      .rst_n  (rst_n),
      .ale    (ale),
      .hi_i   (addr_hi),
      .lo_i   (ad_i[ADDR_W-1:0]),
      .addr_q (live_addr)
   );

   mrb_strobe_sync #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .rd_n      (rd_n),
      .wr_n      (wr_n),
      .psen_n    (psen_n),
      .ad_i      (ad_i),
      .addr_i    (live_addr),
      .wr_commit (wr_commit),
      .rd_finish (rd_finish),
      .cyc_addr  (cyc_addr),
      .cyc_data  (cyc_data)
   );

   mrb_regfile #(
      .ADDR_W         (ADDR_W),
      .DATA_W         (DATA_W),
      .BASE_HI        (BASE_HI),
      .BANK_LO        (BANK_LO),
      .INT_REGISTERED (INT_REGISTERED)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_commit   (wr_commit),
      .rd_finish   (rd_finish),
      .cyc_addr    (cyc_addr),
      .cyc_data    (cyc_data),
      .live_addr   (live_addr),
      .rd_n        (rd_n),
      .psen_n      (psen_n),
      .flag_done   (flag_done),
      .flag_error  (flag_error),
      .flag_need   (flag_need),
      .flag_ready  (flag_ready),
      .app_load    (app_load),
      .app_word    (app_word),
      .ad_o        (ad_o),
      .ad_oe       (ad_oe),
      .data_to_app (data_to_app),
      .app_en      (app_en),
      .start       (start),
      .ctrl_bits   (ctrl_bits),
      .clr_error   (clr_error),
      .clr_need    (clr_need),
      .clr_ready   (clr_ready),
      .int_n       (int_n)
   );

endmodule

// File: rtl/mrb_checker.sv
module mrb_checker #(
   parameter bit INT_REGISTERED = 1'b1
) (
   input logic clk,
   input logic rst_n,
   input logic rd_n,
   input logic psen_n,
   input logic ad_oe,
   input logic flag_error,
   input logic clr_error,
   input logic clr_need,
   input logic clr_ready,
   input logic app_en,
   input logic int_n
);

   assert_drive_in_read_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ad_oe |-> (!rd_n && psen_n));

   assert_need_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_need |=> !clr_need);

   assert_ready_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ready |=> !clr_ready);

   assert_error_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_error |-> $past(flag_error));

   assert_error_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_error |=> !clr_error);

   generate
      if (INT_REGISTERED) begin : g_irq_reg
         assert_irq_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !int_n |-> $past(app_en));
      end else begin : g_irq_comb
         assert_irq_enable_R11: assert property (@(posedge clk) disable iff (!rst_n)
            !int_n |-> app_en);
      end
   endgenerate

endmodule

bind mcu_regbridge mrb_checker #(.INT_REGISTERED(INT_REGISTERED)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .rd_n       (rd_n),
   .psen_n     (psen_n),
   .ad_oe      (ad_oe),
   .flag_error (flag_error),
   .clr_error  (clr_error),
   .clr_need   (clr_need),
   .clr_ready  (clr_ready),
   .app_en     (app_en),
   .int_n      (int_n)
);

// File: tb/mcu_regbridge_test.sv
module mcu_regbridge_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ale = 1'b0;
   logic [7:0] addr_hi = '0;
   logic [7:0] ad_i = '0;
   logic [7:0] ad_o;
   logic       ad_oe;
   logic       rd_n = 1'b1, wr_n = 1'b1, psen_n = 1'b1;
   logic       flag_done = 0, flag_error = 0, flag_need = 0, flag_ready = 0;
   logic       app_load = 1'b0;
   logic [7:0] app_word = '0;
   logic [7:0] data_to_app;
   logic       app_en, start;
   logic [4:0] ctrl_bits;
   logic       clr_error, clr_need, clr_ready, int_n;

   int n_chk = 0, n_fail = 0;
   int cnt_err = 0, cnt_need = 0, cnt_ready = 0;
   bit tb_hit = 0;
   bit int_ok = 0;
   bit int_exp = 1;

   logic [7:0] m_ctrl = '0, m_din = '0, m_dout = '0;

   always #10 clk = ~clk;

   mcu_regbridge uut (
      .clk(clk), .rst_n(rst_n), .ale(ale), .addr_hi(addr_hi), .ad_i(ad_i),
      .ad_o(ad_o), .ad_oe(ad_oe), .rd_n(rd_n), .wr_n(wr_n), .psen_n(psen_n),
      .flag_done(flag_done), .flag_error(flag_error), .flag_need(flag_need),
      .flag_ready(flag_ready), .app_load(app_load), .app_word(app_word),
      .data_to_app(data_to_app), .app_en(app_en), .start(start),
      .ctrl_bits(ctrl_bits), .clr_error(clr_error), .clr_need(clr_need),
      .clr_ready(clr_ready), .int_n(int_n)
   );

   task automatic chk_eq(string req, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic bit hit_f(logic [7:0] hi, logic [7:0] lo);
      return hi == 8'h00 && (lo == 8'h80 || lo == 8'h82 || lo == 8'h84 || lo == 8'h86);
   endfunction

   // reference model checked on every clock
   always @(negedge clk) begin
      if (!rst_n) begin
         int_ok = 0;
      end else begin
         if (clr_error) cnt_err++;
         if (clr_need)  cnt_need++;
         if (clr_ready) cnt_ready++;
         chk_eq("R9", "ad_oe", ad_oe, (!rd_n && psen_n && tb_hit));
         if (int_ok) chk_eq("R11", "int_n", int_n, int_exp);
         int_exp = !(app_en && (flag_done || flag_error || flag_need || flag_ready));
         int_ok = 1;
      end
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic addr_phase(logic [7:0] hi, logic [7:0] lo);
      step(1);
      ale = 1; addr_hi = hi; ad_i = lo;
      step(2);
      ale = 0; tb_hit = hit_f(hi, lo);
      step(1);
   endtask

   task automatic cpu_write(logic [7:0] hi, logic [7:0] lo, logic [7:0] d, bit fetch);
      addr_phase(hi, lo);
      ad_i = d; wr_n = 0; psen_n = !fetch;
      step(5);
      wr_n = 1; psen_n = 1; ad_i = ~d;   // bus changes at the strobe edge
      step(8);
   endtask

   task automatic cpu_read(logic [7:0] hi, logic [7:0] lo, bit fetch,
                           output logic [7:0] v, output logic oe);
      addr_phase(hi, lo);
      ad_i = '0; rd_n = 0; psen_n = !fetch;
      step(3);
      @(negedge clk);
      v = ad_o; oe = ad_oe;
      step(1);
      rd_n = 1; psen_n = 1;
      step(8);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] v;
      logic oe;
      int c0;
      step(3);
      rst_n = 1;
      step(2);
      @(negedge clk);
      chk_eq("R1", "app_en", app_en, 0);
      chk_eq("R1", "start", start, 0);
      chk_eq("R1", "ctrl_bits", ctrl_bits, 0);
      chk_eq("R1", "data_to_app", data_to_app, 0);
      chk_eq("R1", "int_n", int_n, 1);
      chk_eq("R1", "ad_oe", ad_oe, 0);
      chk_eq("R1", "clears", {clr_error, clr_need, clr_ready}, 0);

      // R4 control layout, bit 5 dropped
      cpu_write(8'h00, 8'h82, 8'hFF, 0);
      m_ctrl = 8'hDF;
      chk_eq("R4", "app_en", app_en, 1);
      chk_eq("R4", "start", start, 1);
      chk_eq("R4", "ctrl_bits", ctrl_bits, 5'h1F);
      cpu_read(8'h00, 8'h82, 0, v, oe);
      chk_eq("R4", "ctrl readback", v, m_ctrl);

      // R2 data phase that looks like the input-data address
      cpu_write(8'h00, 8'h82, 8'h84, 0);
      m_ctrl = 8'h84;
      chk_eq("R2", "start", start, 0);
      chk_eq("R2", "ctrl_bits", ctrl_bits, 5'h04);
      chk_eq("R2", "data_to_app", data_to_app, m_din);

      // R5 / R12 input data
      c0 = cnt_need;
      cpu_write(8'h00, 8'h84, 8'h5A, 0);
      m_din = 8'h5A;
      chk_eq("R12", "data_to_app", data_to_app, m_din);
      chk_eq("R5", "clr_need count", cnt_need - c0, 1);
      cpu_read(8'h00, 8'h84, 0, v, oe);
      chk_eq("R5", "din readback", v, m_din);

      // R6 output data
      app_word = 8'hC3; app_load = 1;
      step(1);
      app_load = 0; app_word = 8'h00;
      m_dout = 8'hC3;
      c0 = cnt_ready;
      cpu_read(8'h00, 8'h86, 0, v, oe);
      chk_eq("R6", "dout read", v, m_dout);
      chk_eq("R6", "clr_ready count", cnt_ready - c0, 1);
      cpu_write(8'h00, 8'h86, 8'h77, 0);
      cpu_read(8'h00, 8'h86, 0, v, oe);
      chk_eq("R6", "dout not cpu writable", v, m_dout);

      // R7 / R8 status
      flag_done = 1; flag_error = 1; flag_ready = 1; flag_need = 0;
      c0 = cnt_err;
      cpu_read(8'h00, 8'h80, 0, v, oe);
      chk_eq("R7", "status", v, 8'hC8);
      chk_eq("R8", "clr_error count set", cnt_err - c0, 1);
      flag_done = 0; flag_error = 0; flag_ready = 0; flag_need = 1;
      c0 = cnt_err;
      cpu_read(8'h00, 8'h80, 0, v, oe);
      chk_eq("R7", "status need", v, 8'h10);
      chk_eq("R8", "clr_error count clear", cnt_err - c0, 0);
      flag_need = 0;

      // R11 interrupt
      step(3);
      chk_eq("R11", "int idle", int_n, 1);
      flag_done = 1;
      step(3);
      chk_eq("R11", "int flagged", int_n, 0);
      cpu_write(8'h00, 8'h82, 8'h00, 0);
      m_ctrl = 8'h00;
      chk_eq("R11", "int disabled", int_n, 1);
      flag_done = 0;
      cpu_write(8'h00, 8'h82, 8'h80, 0);
      m_ctrl = 8'h80;

      // R3 foreign base
      cpu_write(8'h01, 8'h84, 8'h11, 0);
      chk_eq("R3", "data_to_app", data_to_app, m_din);
      cpu_read(8'h01, 8'h84, 0, v, oe);
      chk_eq("R3", "ad_oe", oe, 0);

      // R10 fetch cycles
      c0 = cnt_need;
      cpu_write(8'h00, 8'h84, 8'h22, 1);
      chk_eq("R10", "data_to_app", data_to_app, m_din);
      chk_eq("R10", "clr_need count", cnt_need - c0, 0);
      cpu_read(8'h00, 8'h84, 1, v, oe);
      chk_eq("R10", "ad_oe", oe, 0);

      // R13 unmapped
      cpu_write(8'h00, 8'h81, 8'h33, 0);
      chk_eq("R13", "data_to_app", data_to_app, m_din);
      chk_eq("R13", "ctrl", {app_en, start, 1'b0, ctrl_bits}, m_ctrl);
      cpu_read(8'h00, 8'h81, 0, v, oe);
      chk_eq("R13", "ad_oe", oe, 0);

      step(4);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule